// File: doc/BRIEF.md
# Dual-Branch Montgomery Word Element

This block is one processing element of a word-sliced radix-2 Montgomery multiplier. Each element keeps one W-bit word of the running partial result S for the whole multiplication. In every round it uses one multiplier bit x and the reduction bit q. It adds the matching words of Y and M to its word and to the carry from the element below, then shifts the sum right by one bit. A chain of E elements, with element j working on round i in cycle i+j, computes X·Y·2^-n mod M in the range [0, 2M).

When an element runs round i, the most significant bit of its own word from round i-1 is not yet known. That bit is the new least significant bit that the element above produces in the same cycle. The element therefore evaluates both sums in parallel, one assuming the bit is 0 and one assuming it is 1. The neighbour's bit picks the carry and the upper bits at the end of the cycle, so neighbours are one cycle apart rather than two. The new least significant bit sent downward does not depend on that unknown bit, so no combinational path runs along the chain.

The element for the top word has a single branch. Nothing lies above it, so its whole word is known and the shifted sum is stored directly. Operand storage, the round sequencing and the final conditional subtraction belong to the surrounding logic.

Top module: `mont_word_pe`

## Requirements
- R1: After reset, and in the cycle after a start_i pulse, word_o and carry_o are zero. start_i takes priority over en_i.
- R2: In a cycle with en_i low and start_i low, word_o bits [W-2:0] and carry_o keep their values whatever the other inputs do. The top variant keeps its whole word.
- R3: In an active cycle (en_i high), lsb_o equals bit 0 of old_word + x_i·y_i + q_i·m_i + carry_i, and it has the same value for nb_i = 0 and nb_i = 1.
- R4: In the non-top variant, the old word is {b, word_o[W-2:0]}. b is nb_i if the previous cycle was active and not a start; otherwise b is the stored word_o[W-1]. After an active cycle, word_o[W-2:0] holds bits [W-1:1] of the sum and carry_o holds sum >> W.
- R5: In the non-top variant, after a cycle that follows an active cycle (and carries no start), word_o[W-1] equals the nb_i applied in that cycle. Otherwise it keeps its value.
- R6: In the top variant (TOP_WORD = 1), after an active cycle word_o holds bits [W:1] of the sum of the old word and the addends. carry_o stays 0, and nb_i has no effect on any output.
- R7: A chain of 3 elements with W = 4 runs rounds i = 0..7. Element j takes round i in cycle i+j with q_i = bit 0 of (S + x_i·Y). The result is the concatenation of the word outputs, least significant word from element 0, and it equals the value of the loop S = (S + x_i·Y + q_i·M)/2 started from S = 0.
- R8: carry_o is 2 bits wide and never exceeds 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous clear before round 0 |
| en_i | input | 1 | This cycle carries a round for this element |
| x_i | input | 1 | Multiplier bit of the round |
| q_i | input | 1 | Reduction bit of the round |
| y_i | input | W | Matching word of Y |
| m_i | input | W | Matching word of M |
| carry_i | input | 2 | Carry from the element below |
| nb_i | input | 1 | New least significant bit of the element above |
| word_o | output | W | Registered word of S |
| carry_o | output | 2 | Registered carry to the element above |
| lsb_o | output | 1 | New least significant bit for the element below |

## Verification
A random per-cycle sweep drives a stand-alone element of each variant, with W = 4. It mixes start pulses, idle cycles, carries 0 to 2 and arbitrary operand words against an arithmetic model. Applying both neighbour bits in the same active cycle shows that the downward bit is free of the unresolved bit. The sweep also separates the correct branch choice from a stale or swapped one. Idle cycles between active ones show whether the msb latch happens at the right time and whether idle inputs are ignored. Complete multiplications on a three-element chain are compared with a bit-serial loop. They use random odd moduli, plus X = 0, M = 1 and all-ones operands with M = 255, and these exercise the largest carries and the top-word bound.

// File: rtl/mont_pe_pkg.sv
package mont_pe_pkg;
  localparam int unsigned CARRY_W = 2;
  typedef logic [CARRY_W-1:0] carry_t;
endpackage

// File: rtl/mont_word_add.sv
module mont_word_add
  import mont_pe_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]         old_i,
  input  logic                 x_i,
  input  logic                 q_i,
  input  logic [W-1:0]         y_i,
  input  logic [W-1:0]         m_i,
  input  carry_t               carry_i,
  output logic [W+CARRY_W-1:0] sum_o
);
  localparam int unsigned SW = W + CARRY_W;

  logic [SW-1:0] y_term, m_term;

  always_comb begin
    y_term = x_i ? {{CARRY_W{1'b0}}, y_i} : '0;
    m_term = q_i ? {{CARRY_W{1'b0}}, m_i} : '0;
    sum_o  = {{CARRY_W{1'b0}}, old_i} + y_term + m_term + {{W{1'b0}}, carry_i};
  end
endmodule

// File: rtl/mont_word_sel.sv
module mont_word_sel
  import mont_pe_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W:0]   hi0_i,   // sum[W+1:1], branch msb = 0
  input  logic [W:0]   hi1_i,   // sum[W+1:1], branch msb = 1
  input  logic         sel_i,
  output logic [W-2:0] low_o,
  output carry_t       carry_o
);
  always_comb begin
    low_o   = sel_i ? hi1_i[W-2:0] : hi0_i[W-2:0];
    carry_o = sel_i ? hi1_i[W:W-1] : hi0_i[W:W-1];
  end
endmodule

// File: rtl/mont_word_pe.sv
module mont_word_pe
  import mont_pe_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter bit          TOP_WORD = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         en_i,
  input  logic         x_i,
  input  logic         q_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] m_i,
  input  carry_t       carry_i,
  input  logic         nb_i,
  output logic [W-1:0] word_o,
  output carry_t       carry_o,
  output logic         lsb_o
);
  localparam int unsigned SW = W + CARRY_W;
  localparam int unsigned LW = W - 1;

  if (TOP_WORD) begin : g_top
    logic [W-1:0]  word_q;
    logic [SW-1:0] sum;
    logic          unused_top;

    mont_word_add #(.W(W)) u_add (
      .old_i(word_q), .x_i(x_i), .q_i(q_i), .y_i(y_i), .m_i(m_i),
      .carry_i(carry_i), .sum_o(sum)
    );

    // result is bounded below 2^W once shifted; top sum bit stays clear
    assign unused_top = nb_i ^ sum[SW-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (start_i) word_q <= '0;
      else if (en_i)    word_q <= sum[W:1];
    end

    assign word_o  = word_q;
    assign carry_o = '0;
    assign lsb_o   = sum[0];
  end else begin : g_mid
    logic [LW-1:0] low_q, low_d;
    logic          msb_q, en_q, msb_eff;
    carry_t        carry_q, carry_d;
    logic [SW-1:0] sum0, sum1;
    logic          unused_b1;

    // msb of previous round resolves this cycle when the previous cycle was active
    assign msb_eff = en_q ? nb_i : msb_q;

    mont_word_add #(.W(W)) u_add0 (
      .old_i({1'b0, low_q}), .x_i(x_i), .q_i(q_i), .y_i(y_i), .m_i(m_i),
      .carry_i(carry_i), .sum_o(sum0)
    );
    mont_word_add #(.W(W)) u_add1 (
      .old_i({1'b1, low_q}), .x_i(x_i), .q_i(q_i), .y_i(y_i), .m_i(m_i),
      .carry_i(carry_i), .sum_o(sum1)
    );
    mont_word_sel #(.W(W)) u_sel (
      .hi0_i(sum0[SW-1:1]), .hi1_i(sum1[SW-1:1]), .sel_i(msb_eff),
      .low_o(low_d), .carry_o(carry_d)
    );

    assign unused_b1 = sum1[0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        low_q   <= '0;
        msb_q   <= 1'b0;
        carry_q <= '0;
        en_q    <= 1'b0;
      end else if (start_i) begin
        low_q   <= '0;
        msb_q   <= 1'b0;
        carry_q <= '0;
        en_q    <= 1'b0;
      end else begin
        en_q <= en_i;
        if (en_i) begin
          low_q   <= low_d;
          carry_q <= carry_d;
        end
        if (en_q) msb_q <= nb_i;
      end
    end

    assign word_o  = {msb_q, low_q};
    assign carry_o = carry_q;
    assign lsb_o   = sum0[0];
  end
endmodule

// File: rtl/mont_word_pe_chk.sv
module mont_word_pe_chk
  import mont_pe_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter bit          TOP_WORD = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         en_i,
  input logic         nb_i,
  input logic [W-1:0] word_o,
  input carry_t       carry_o
);
  logic en_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_d <= 1'b0;
    else         en_d <= en_i & ~start_i;
  end

  assert_start_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (word_o == '0 && carry_o == '0));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> ($stable(word_o[W-2:0]) && $stable(carry_o)));

  assert_carry_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o != 2'd3);

  if (TOP_WORD) begin : g_top_chk
    assert_top_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !start_i) |=> $stable(word_o));
  end else begin : g_mid_chk
    assert_msb_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_d && !start_i) |=> (word_o[W-1] == $past(nb_i)));
    assert_msb_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_d && !start_i) |=> $stable(word_o[W-1]));
  end
endmodule

bind mont_word_pe mont_word_pe_chk #(.W(W), .TOP_WORD(TOP_WORD)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .en_i(en_i),
  .nb_i(nb_i), .word_o(word_o), .carry_o(carry_o)
);

// File: tb/sim_mont_word_pe.sv
module sim_mont_word_pe;
  localparam int W = 4;
  localparam int E = 3;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // stand-alone elements
  logic         s_start = 0, s_en = 0, s_x = 0, s_q = 0, s_nb = 0;
  logic [W-1:0] s_y = '0, s_m = '0;
  logic [1:0]   s_cin = '0;
  logic [W-1:0] so_word, to_word;
  logic [1:0]   so_carry, to_carry;
  logic         so_lsb, to_lsb;

  for (genvar g = 0; g < 1; g++) begin : g_solo
    mont_word_pe #(.W(W), .TOP_WORD(1'b0)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .en_i(s_en), .x_i(s_x), .q_i(s_q),
      .y_i(s_y), .m_i(s_m), .carry_i(s_cin), .nb_i(s_nb),
      .word_o(so_word), .carry_o(so_carry), .lsb_o(so_lsb));
  end
  for (genvar g = 0; g < 1; g++) begin : g_solo_top
    mont_word_pe #(.W(W), .TOP_WORD(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .en_i(s_en), .x_i(s_x), .q_i(s_q),
      .y_i(s_y), .m_i(s_m), .carry_i(s_cin), .nb_i(s_nb),
      .word_o(to_word), .carry_o(to_carry), .lsb_o(to_lsb));
  end

  // chain of E elements
  logic         c_start = 0;
  logic [E-1:0] c_en = '0, c_x = '0, c_q = '0;
  logic [W-1:0] c_y [E];
  logic [W-1:0] c_m [E];
  logic [W-1:0] c_word [E];
  logic [1:0]   c_carry [E];
  logic [E-1:0] c_lsb;

  for (genvar g = 0; g < E; g++) begin : g_chain
    logic [1:0] cin;
    logic       nb;
    if (g == 0) begin : g_lo
      assign cin = 2'b00;
    end else begin : g_up
      assign cin = c_carry[g-1];
    end
    if (g == E-1) begin : g_hi
      assign nb = 1'b0;
    end else begin : g_dn
      assign nb = c_lsb[g+1];
    end
    mont_word_pe #(.W(W), .TOP_WORD(g == E-1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(c_start), .en_i(c_en[g]), .x_i(c_x[g]),
      .q_i(c_q[g]), .y_i(c_y[g]), .m_i(c_m[g]), .carry_i(cin), .nb_i(nb),
      .word_o(c_word[g]), .carry_o(c_carry[g]), .lsb_o(c_lsb[g]));
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // models of the stand-alone elements
  int sm_low = 0, sm_msb = 0, sm_c = 0, sm_enq = 0, tw = 0;

  task automatic unit_sweep(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      int add, s, lsb_m, lsb_t, mb, prev_enq;
      @(negedge clk);
      s_start = ($urandom % 12) == 0;
      s_en    = ($urandom % 4) != 0;
      s_x     = 1'($urandom);
      s_q     = 1'($urandom);
      s_y     = W'($urandom);
      s_m     = W'($urandom);
      s_cin   = 2'($urandom % 3);
      add   = (s_x ? int'(s_y) : 0) + (s_q ? int'(s_m) : 0) + int'(s_cin);
      lsb_m = (sm_low + add) & 1;
      lsb_t = (tw + add) & 1;
      if (s_en && !s_start) begin
        s_nb = 1'b0; #1;
        chk(so_lsb == lsb_m[0], "R3 lsb nb=0", int'(so_lsb), lsb_m);
        chk(to_lsb == lsb_t[0], "R6 top lsb nb=0", int'(to_lsb), lsb_t);
        s_nb = 1'b1; #1;
        chk(so_lsb == lsb_m[0], "R3 lsb nb=1", int'(so_lsb), lsb_m);
        chk(to_lsb == lsb_t[0], "R6 top lsb nb=1", int'(to_lsb), lsb_t);
      end
      s_nb = 1'($urandom);
      prev_enq = sm_enq;
      if (s_start) begin
        sm_low = 0; sm_msb = 0; sm_c = 0; sm_enq = 0; tw = 0;
      end else begin
        mb = sm_enq ? int'(s_nb) : sm_msb;
        if (s_en) begin
          s = ((mb << (W-1)) | sm_low) + add;
          sm_low = (s >> 1) & ((1 << (W-1)) - 1);
          sm_c = s >> W;
          s = tw + add;
          tw = (s >> 1) & ((1 << W) - 1);
        end
        if (sm_enq != 0) sm_msb = int'(s_nb);
        sm_enq = s_en ? 1 : 0;
      end
      @(posedge clk); #1;
      if (s_start) begin
        chk(so_word == 0 && so_carry == 0, "R1 start clear", int'(so_word), 0);
        chk(to_word == 0, "R1 top start clear", int'(to_word), 0);
      end else if (s_en) begin
        chk(int'(so_word[W-2:0]) == sm_low, "R4 low bits", int'(so_word[W-2:0]), sm_low);
        chk(int'(so_carry) == sm_c, "R4 carry", int'(so_carry), sm_c);
        chk(int'(to_word) == tw, "R6 top word", int'(to_word), tw);
      end else begin
        chk(int'(so_word[W-2:0]) == sm_low && int'(so_carry) == sm_c, "R2 idle hold",
            int'(so_word[W-2:0]), sm_low);
        chk(int'(to_word) == tw, "R2 top idle hold", int'(to_word), tw);
      end
      if (!s_start)
        chk(int'(so_word[W-1]) == sm_msb, prev_enq != 0 ? "R5 msb latch" : "R5 msb hold",
            int'(so_word[W-1]), sm_msb);
      chk(so_carry <= 2, "R8 carry range", int'(so_carry), 2);
      chk(to_carry == 0, "R6 top carry", int'(to_carry), 0);
    end
    @(negedge clk);
    s_en = 1'b0; s_start = 1'b0;
  endtask

  task automatic mult(input int xv, input int yv, input int mv);
    bit [N-1:0] qa;
    int ref_s, got, t;
    @(negedge clk);
    c_start = 1'b1;
    c_en = '0;
    for (int j = 0; j < E; j++) begin
      c_y[j] = W'(yv >> (W*j));
      c_m[j] = W'(mv >> (W*j));
    end
    for (int tt = 0; tt < N + E - 1; tt++) begin
      @(negedge clk);
      c_start = 1'b0;
      if (tt < N) qa[tt] = c_word[0][0] ^ (xv[tt] & yv[0]);
      for (int j = 0; j < E; j++) begin
        int i;
        i = tt - j;
        c_en[j] = (i >= 0 && i < N);
        c_x[j]  = c_en[j] ? xv[i] : 1'b0;
        c_q[j]  = c_en[j] ? qa[i] : 1'b0;
      end
      @(posedge clk);
    end
    @(negedge clk);
    c_en = '0;
    got = 0;
    for (int j = 0; j < E; j++) got = got | (int'(c_word[j]) << (W*j));
    ref_s = 0;
    for (int i = 0; i < N; i++) begin
      t = ref_s + (xv[i] ? yv : 0);
      if (t[0]) t = t + mv;
      ref_s = t >> 1;
    end
    chk(got == ref_s, "R7 chain result", got, ref_s);
    for (int j = 0; j < E; j++)
      chk(c_carry[j] <= 2, "R8 chain carry", int'(c_carry[j]), 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int j = 0; j < E; j++) begin
      c_y[j] = '0;
      c_m[j] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(so_word == 0 && so_carry == 0, "R1 reset solo", int'(so_word), 0);
    chk(to_word == 0 && to_carry == 0, "R1 reset top", int'(to_word), 0);
    for (int j = 0; j < E; j++)
      chk(c_word[j] == 0 && c_carry[j] == 0, "R1 reset chain", int'(c_word[j]), 0);

    unit_sweep(3000);

    mult(0, 100, 201);
    mult(0, 0, 1);
    mult(254, 254, 255);
    mult(255, 255, 255);
    mult(1, 1, 3);
    for (int k = 0; k < 400; k++) begin
      int mv, xv, yv;
      mv = int'($urandom_range(1, 127)) * 2 + 1;
      xv = int'($urandom_range(0, mv - 1));
      yv = int'($urandom_range(0, mv - 1));
      mult(xv, yv, mv);
    end
    finish_run();
  end
endmodule